// File: doc/BRIEF.md
# DC-Balanced Embedded-Clock Pixel Serializer

This block turns one parallel pixel per pixel period into a 28-bit serial frame on a single output line. Each pixel is 24 colour bits plus three video control signals: vertical sync, horizontal sync and data enable. A frame opens with a high clock marker and closes with a low one, so a receiver can recover the frame timing from the data alone. The colour payload is scrambled with a free-running LFSR. A balance flag says whether the scrambled payload was inverted, which keeps the running disparity of the line near zero. An in-band control bit carries the three control signals in turn, interleaved with a parity bit over the previous payload.

The block runs on the bit clock, which is 28 times the pixel rate. A one-cycle pixel strobe marks each frame boundary and captures the pixel presented with it. A power-down input silences the line and returns all coding state to its reset values. An 18-bit colour mode forces the two low bits of each colour byte to zero before scrambling.

Top module: `pixel_serializer`

## Requirements
- R1: After reset, and whenever no frame is in flight, `ser_o` is low. Once the 28 bits of a frame have been sent with no new strobe, the line stays low.
- R2: On the bit clock cycle after an accepted strobe, `ser_o` gives frame bit 0, then one bit per cycle. Bit 0 is 1, bits 1..24 are payload bits 0..23, bit 25 is the balance flag, bit 26 is the control bit and bit 27 is 0.
- R3: Before inversion, the payload is the (masked) pixel XOR a key, where key bit i = L[i mod 16]. L is a 16-bit LFSR seeded to 0xACE1 that shifts left with new bit 0 = L15^L4^L3^L2. It advances once per accepted frame, after that frame has used it.
- R4: When `mode18_i` is high, pixel bits 0, 1, 8, 9, 16 and 17 are forced to 0 before scrambling.
- R5: Let D be the ones-minus-zeros count of the scrambled payload. The payload is inverted and the balance flag is 1 exactly when D is non-zero, the running disparity is non-zero, and the two have the same sign. Otherwise the flag is 0 and the payload is sent unchanged.
- R6: The running disparity starts at 0 and is increased after each frame by the ones-minus-zeros count of the payload as sent. It stays within -24..+24.
- R7: The control bit follows a six-frame cycle:
  - phase 0 carries DE, phase 2 carries HS and phase 4 carries VS;
  - phases 1, 3 and 5 carry the XOR of the 24 payload bits sent in the previous frame (0 for the first frame after reset or power-down);
  - control inputs are sampled with the strobe.
- R8: While `pd_i` is high:
  - `ser_o` is low from the next cycle on, and strobes are ignored;
  - the LFSR, running disparity, control phase and parity are reset.
  The first strobe after release sends the frame that would follow a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, 28 cycles per pixel |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pd_i | input | 1 | Power-down |
| pix_stb_i | input | 1 | One-cycle pixel strobe, starts a frame |
| mode18_i | input | 1 | 18-bit colour mode |
| pix_data_i | input | 24 | Colour word, three 8-bit channels |
| vsync_i | input | 1 | Vertical sync |
| hsync_i | input | 1 | Horizontal sync |
| de_i | input | 1 | Data enable |
| ser_o | output | 1 | Serial line |

## Verification
The hardest situations to reach from the ports are the inversion decision's edge cases:
- a scrambled payload with zero disparity;
- a payload whose disparity sign matches a non-zero running disparity;
- a payload that would push the running disparity to its ±24 limit.

Scrambling hides these patterns behind the LFSR. The bench therefore tracks the LFSR state itself and presents pixel = key XOR wanted pattern. This forces all-ones, all-zeros, balanced and near-empty scrambled payloads. Power-down is used first, so these runs start from zero disparity.

// File: rtl/pser_pkg.sv
package pser_pkg;
  localparam logic [15:0] LFSR_SEED_DEF = 16'hACE1;
  localparam logic [15:0] LFSR_TAPS_DEF = 16'h801C; // x^16+x^5+x^4+x^3+1
  localparam int unsigned N_PHASE = 6;

  typedef enum logic [2:0] {
    PH_DE   = 3'd0,
    PH_PAR0 = 3'd1,
    PH_HS   = 3'd2,
    PH_PAR1 = 3'd3,
    PH_VS   = 3'd4,
    PH_PAR2 = 3'd5
  } dca_phase_e;
endpackage

// File: rtl/pser_lfsr.sv
module pser_lfsr #(
  parameter int unsigned     W    = 16,
  parameter logic [W-1:0]    SEED = 16'hACE1,
  parameter logic [W-1:0]    TAPS = 16'h801C
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         adv_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q;
  logic         fb;

  assign fb      = ^(state_q & TAPS);
  assign state_o = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= SEED;
    else if (clr_i) state_q <= SEED;
    else if (adv_i) state_q <= {state_q[W-2:0], fb};
  end

  a_r3_lfsr_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
  a_r3_lfsr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !clr_i) |=> $stable(state_q));
endmodule

// File: rtl/pser_balance.sv
module pser_balance #(
  parameter int unsigned PIX_W = 24,
  parameter int unsigned RD_W  = 7
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   load_i,
  input  logic [PIX_W-1:0]       scr_i,
  output logic [PIX_W-1:0]       pay_o,
  output logic                   inv_o,
  output logic signed [RD_W-1:0] rd_o
);
  logic [RD_W-1:0]        ones;
  logic signed [RD_W-1:0] disp;
  logic signed [RD_W-1:0] rd_q, rd_d;

  always_comb begin
    ones = '0;
    for (int i = 0; i < PIX_W; i++) ones = ones + RD_W'(scr_i[i]);
  end

  assign disp  = $signed((ones << 1) - RD_W'(PIX_W));
  assign inv_o = (disp != 0) && (rd_q != 0) && (disp[RD_W-1] == rd_q[RD_W-1]);
  assign pay_o = inv_o ? ~scr_i : scr_i;
  assign rd_d  = inv_o ? (rd_q - disp) : (rd_q + disp);
  assign rd_o  = rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rd_q <= '0;
    else if (clr_i)  rd_q <= '0;
    else if (load_i) rd_q <= rd_d;
  end

  a_r6_rd_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_q <= $signed(RD_W'(PIX_W))) && (rd_q >= -$signed(RD_W'(PIX_W))));
  a_r5_pull_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i && rd_q > 0 && disp > 0) |=> rd_q < $past(rd_q));
  a_r5_pull_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i && rd_q < 0 && disp < 0) |=> rd_q > $past(rd_q));
endmodule

// File: rtl/pser_ctrl.sv
module pser_ctrl
  import pser_pkg::*;
#(
  parameter int unsigned PIX_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic             vsync_i,
  input  logic             hsync_i,
  input  logic             de_i,
  input  logic [PIX_W-1:0] pay_i,
  output logic             dca_o
);
  dca_phase_e phase_q, phase_d;
  logic       par_q;

  always_comb begin
    case (phase_q)
      PH_DE:   dca_o = de_i;
      PH_HS:   dca_o = hsync_i;
      PH_VS:   dca_o = vsync_i;
      default: dca_o = par_q;
    endcase
    phase_d = (phase_q == PH_PAR2) ? PH_DE : dca_phase_e'(phase_q + 3'd1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_DE;
      par_q   <= 1'b0;
    end else if (clr_i) begin
      phase_q <= PH_DE;
      par_q   <= 1'b0;
    end else if (load_i) begin
      phase_q <= phase_d;
      par_q   <= ^pay_i;
    end
  end

  a_r7_phase_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(phase_q) < N_PHASE);
  a_r7_phase_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !clr_i) |=> $stable(phase_q) && $stable(par_q));
endmodule

// File: rtl/pser_shift.sv
module pser_shift #(
  parameter int unsigned FRAME_W = 28
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               ser_o
);
  logic [FRAME_W-1:0] sreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sreg_q <= '0;
    else if (clr_i)  sreg_q <= '0;
    else if (load_i) sreg_q <= frame_i;
    else             sreg_q <= {1'b0, sreg_q[FRAME_W-1:1]};
  end

  assign ser_o = sreg_q[0];

  a_r2_marker_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i) |=> ser_o);
  a_r8_pd_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !ser_o);
endmodule

// File: rtl/pixel_serializer.sv
module pixel_serializer
  import pser_pkg::*;
#(
  parameter int unsigned          PIX_W     = 24,
  parameter int unsigned          LFSR_W    = 16,
  parameter logic [LFSR_W-1:0]    LFSR_SEED = LFSR_SEED_DEF,
  parameter logic [LFSR_W-1:0]    LFSR_TAPS = LFSR_TAPS_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_i,
  input  logic             pix_stb_i,
  input  logic             mode18_i,
  input  logic [PIX_W-1:0] pix_data_i,
  input  logic             vsync_i,
  input  logic             hsync_i,
  input  logic             de_i,
  output logic             ser_o
);
  localparam int unsigned FRAME_W = PIX_W + 4;
  localparam int unsigned RD_W    = $clog2(PIX_W + 1) + 2;

  logic                   load;
  logic [LFSR_W-1:0]      lfsr;
  logic [PIX_W-1:0]       key, mask18, pix_m, scr, pay;
  logic                   inv, dca;
  logic signed [RD_W-1:0] rd;
  logic [FRAME_W-1:0]     frame;

  assign load = pix_stb_i & ~pd_i;

  for (genvar i = 0; i < PIX_W; i++) begin : g_bit
    assign key[i]    = lfsr[i % LFSR_W];
    assign mask18[i] = ((i % 8) >= 2); // drop two LSBs per channel
  end

  assign pix_m = mode18_i ? (pix_data_i & mask18) : pix_data_i;
  assign scr   = pix_m ^ key;
  assign frame = {1'b0, dca, inv, pay, 1'b1};

  pser_lfsr #(.W(LFSR_W), .SEED(LFSR_SEED), .TAPS(LFSR_TAPS)) lfsr_i (
    .clk_i, .rst_ni, .clr_i(pd_i), .adv_i(load), .state_o(lfsr)
  );

  pser_balance #(.PIX_W(PIX_W), .RD_W(RD_W)) bal_i (
    .clk_i, .rst_ni, .clr_i(pd_i), .load_i(load), .scr_i(scr),
    .pay_o(pay), .inv_o(inv), .rd_o(rd)
  );

  pser_ctrl #(.PIX_W(PIX_W)) ctrl_i (
    .clk_i, .rst_ni, .clr_i(pd_i), .load_i(load),
    .vsync_i, .hsync_i, .de_i, .pay_i(pay), .dca_o(dca)
  );

  pser_shift #(.FRAME_W(FRAME_W)) shift_i (
    .clk_i, .rst_ni, .clr_i(pd_i), .load_i(load), .frame_i(frame), .ser_o
  );

  a_r8_state_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |=> (rd == 0) && (lfsr == LFSR_SEED));
endmodule

// File: tb/pixel_serializer_tb_top.sv
module pixel_serializer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd = 1'b0, stb = 1'b0, m18 = 1'b0, vs = 1'b0, hs = 1'b0, de = 1'b0;
  logic [23:0] data = '0;
  logic ser;

  int n_chk = 0, n_fail = 0;
  bit  done = 1'b0;

  logic [15:0] m_lfsr;
  int          m_rd, m_ph;
  logic        m_par;

  always #10 clk = ~clk;

  pixel_serializer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pd_i(pd), .pix_stb_i(stb), .mode18_i(m18),
    .pix_data_i(data), .vsync_i(vs), .hsync_i(hs), .de_i(de), .ser_o(ser)
  );

  // {data, vs, hs, de, m18}
  localparam logic [27:0] STIM [0:9] = '{
    {24'h000000, 4'b0010}, {24'hFFFFFF, 4'b0000}, {24'h123456, 4'b0110},
    {24'hA5A5A5, 4'b1000}, {24'h00FF00, 4'b1110}, {24'hFFFFFF, 4'b0011},
    {24'h0F0F0F, 4'b1101}, {24'hDEADBE, 4'b0100}, {24'h800001, 4'b1011},
    {24'h7E7E7E, 4'b0010}
  };

  function automatic logic [23:0] key_of(input logic [15:0] l);
    logic [23:0] k;
    for (int i = 0; i < 24; i++) k[i] = l[i % 16];
    return k;
  endfunction

  task automatic model_reset();
    m_lfsr = 16'hACE1; m_rd = 0; m_ph = 0; m_par = 1'b0;
  endtask

  task automatic model_frame(input logic [23:0] d, input logic v, h, e, s18,
                             output logic [27:0] fr);
    logic [23:0] scr, pay;
    int          ones, dsp;
    logic        inv, dca;
    scr  = (s18 ? (d & 24'hFCFCFC) : d) ^ key_of(m_lfsr);
    ones = $countones(scr);
    dsp  = 2 * ones - 24;
    inv  = (dsp != 0) && (m_rd != 0) && ((dsp > 0) == (m_rd > 0));
    pay  = inv ? ~scr : scr;
    case (m_ph)
      0: dca = e;
      2: dca = h;
      4: dca = v;
      default: dca = m_par;
    endcase
    fr     = {1'b0, dca, inv, pay, 1'b1};
    m_rd   = inv ? m_rd - dsp : m_rd + dsp;
    m_ph   = (m_ph + 1) % 6;
    m_par  = ^pay;
    m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[4] ^ m_lfsr[3] ^ m_lfsr[2]};
  endtask

  task automatic check(input bit ok, input string req, input logic [27:0] got,
                       input logic [27:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // call at a falling edge; returns at the falling edge holding bit 27
  task automatic send(input logic [23:0] d, input logic v, h, e, s18,
                      input string req, output logic [27:0] got);
    logic [27:0] exp;
    model_frame(d, v, h, e, s18, exp);
    data = d; vs = v; hs = h; de = e; m18 = s18; stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
    got[0] = ser;
    for (int k = 1; k < 28; k++) begin
      @(negedge clk);
      got[k] = ser;
    end
    check(got == exp, req, got, exp);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [27:0] got;
    logic [23:0] k;
    bit          quiet;
    model_reset();
    repeat (3) @(negedge clk);
    check(ser == 1'b0, "R1 reset low", 28'(ser), 28'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ser == 1'b0, "R1 idle after reset", 28'(ser), 28'd0);

    // table walk: back-to-back frames, R2 R3 R4 R5 R6 R7
    for (int i = 0; i < 10; i++) begin
      send(STIM[i][27:4], STIM[i][3], STIM[i][2], STIM[i][1], STIM[i][0],
           "R2/R3/R4/R5/R6/R7 table frame", got);
      check(got[0] == 1'b1 && got[27] == 1'b0, "R2 clock markers",
            {26'd0, got[27], got[0]}, 28'd1);
    end

    // R1: line stays low once the frame has drained
    quiet = 1'b1;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (ser) quiet = 1'b0;
    end
    check(quiet, "R1 idle after frame", 28'(!quiet), 28'd0);

    // R8: power-down mid-frame, strobes ignored
    data = 24'h55AA55; stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
    repeat (4) @(negedge clk);
    pd = 1'b1;
    quiet = 1'b1;
    for (int c = 0; c < 30; c++) begin
      stb = (c % 5 == 0);
      @(negedge clk);
      if (ser) quiet = 1'b0;
    end
    stb = 1'b0;
    check(quiet, "R8 power-down holds line low", 28'(!quiet), 28'd0);
    pd = 1'b0;
    model_reset();
    @(negedge clk);
    send(24'hC0FFEE, 1'b1, 1'b0, 1'b1, 1'b0, "R8 first frame after release", got);

    // R5/R6 directed: force scrambled patterns from zero disparity
    pd = 1'b1;
    @(negedge clk);
    pd = 1'b0;
    model_reset();
    @(negedge clk);
    k = key_of(m_lfsr);
    send(k ^ 24'hFFFFFF, 1'b0, 1'b0, 1'b0, 1'b0, "R5 all ones rd zero", got);
    check(got[25] == 1'b0, "R5 no invert at rd zero", 28'(got[25]), 28'd0);
    k = key_of(m_lfsr);
    send(k ^ 24'hFFFFFF, 1'b0, 1'b0, 1'b0, 1'b0, "R5 all ones rd +24", got);
    check(got[25] == 1'b1 && got[24:1] == 24'h0, "R5 invert same sign",
          {3'd0, got[25], got[24:1]}, {4'd1, 24'h0});
    k = key_of(m_lfsr);
    send(k ^ 24'h000FFF, 1'b0, 1'b0, 1'b0, 1'b0, "R5 balanced payload", got);
    check(got[25] == 1'b0, "R5 zero disparity no invert", 28'(got[25]), 28'd0);
    k = key_of(m_lfsr);
    send(k, 1'b0, 1'b0, 1'b0, 1'b0, "R6 all zeros to -24", got);
    check(got[25] == 1'b0 && got[24:1] == 24'h0, "R6 reach -24",
          {3'd0, got[25], got[24:1]}, 28'd0);
    k = key_of(m_lfsr);
    send(k ^ 24'h000001, 1'b0, 1'b0, 1'b0, 1'b0, "R6 pull back from -24", got);
    check(got[25] == 1'b1, "R5 invert negative sign", 28'(got[25]), 28'd1);

    // R4: 18-bit mode zeros channel LSBs before scrambling
    k = key_of(m_lfsr);
    send(24'hFFFFFF, 1'b1, 1'b1, 1'b1, 1'b1, "R4 18-bit frame", got);
    check(((got[24:1] ^ {24{got[25]}} ^ k) & 24'h030303) == 24'h0,
          "R4 masked bits", 28'(got[24:1] ^ {24{got[25]}} ^ k), 28'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule